// File: doc/BRIEF.md
# Presettable Up/Down Counter with Wrap Flags

A synchronous binary counter that steps one count up or one count down on each enabled clock edge. A direction input selects which way it counts. Every count bit is registered on the same edge, so all bits change together. A parallel load strobe presets the counter to any value, which becomes the starting point for the count that follows. An active-low asynchronous clear forces the count to zero.

Two active-low status outputs mark a wrap-around. `carry_no` drops during the cycle in which an up-step will roll the maximum value over to zero. `borrow_no` drops during the cycle in which a down-step will roll zero back to the maximum. Either flag can feed the enable of a following stage. The overflow bit past the top of the count is dropped, so the value always stays within WIDTH bits. WIDTH defaults to 4.

Top module: `bidir_preset_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 immediately, without waiting for a clock edge, and both carry_no and borrow_no are high.
- R2: With rst_ni high, load_i low, en_i high and up_i = 1 (up), count_o increases by exactly 1 on each rising clock edge.
- R3: With rst_ni high, load_i low, en_i high and up_i = 0 (down), count_o decreases by exactly 1 on each rising clock edge.
- R4: Counting up from the all-ones value (1111) gives 0000 on the next edge, and the overflow bit is discarded.
- R5: Counting down from 0000 gives the all-ones value (1111) on the next edge.
- R6: carry_no is low exactly when all of these hold: count_o is all ones, up_i = 1, en_i = 1, load_i = 0 and rst_ni = 1. At every other time it is high.
- R7: borrow_no is low exactly when all of these hold: count_o is 0, up_i = 0, en_i = 1, load_i = 0 and rst_ni = 1. At every other time it is high.
- R8: With load_i low and en_i low, count_o keeps its value across clock edges, and both flags stay high.
- R9: With load_i high, the next rising edge writes load_val_i into count_o, whatever the values of en_i and up_i.
- R10: A low rst_ni overrides a high load_i, and count_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_i | input | 1 | Parallel preset strobe |
| load_val_i | input | WIDTH | Preset value |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 = up, 0 = down |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Active-low up-wrap flag |
| borrow_no | output | 1 | Active-low down-wrap flag |

## Verification
The bench presets each of the 16 states and steps once up and once down from each one. This catches a wrong toggle chain, which would skip values or jump by more than one at the carry boundaries. The flags are checked in every one of these cycles. A flag that ignores enable, load or direction would then pulse on a hold, on a preset, or on the wrong wrap. The priority tests apply load together with enable, and clear together with load. A design with the priorities reversed would count past the preset or leave the clear waiting for a clock edge.

// File: rtl/counter_pkg.sv
package counter_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/cnt_step.sv
// Synchronous toggle chain: bit i flips when all lower bits sit at the
// terminal level for the current direction (ones going up, zeros going down).
module cnt_step #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             term_o
);
  import counter_pkg::*;

  logic [WIDTH:0] all_ones;
  logic [WIDTH:0] all_zeros;
  dir_e           dir;

  assign dir          = dir_e'(up_i);
  assign all_ones[0]  = 1'b1;
  assign all_zeros[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign all_ones[i+1]  = all_ones[i] & cur_i[i];
    assign all_zeros[i+1] = all_zeros[i] & ~cur_i[i];
    assign nxt_o[i] = cur_i[i] ^ ((dir == DIR_UP) ? all_ones[i] : all_zeros[i]);
  end

  // Terminal state for this direction: the next step wraps.
  assign term_o = (dir == DIR_UP) ? all_ones[WIDTH] : all_zeros[WIDTH];
endmodule

// File: rtl/cnt_flags.sv
module cnt_flags (
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  input  logic up_i,
  input  logic term_i,
  output logic carry_no,
  output logic borrow_no
);
  logic wrap;

  // A wrap only happens on a real count step.
  assign wrap      = rst_ni & ~load_i & en_i & term_i;
  assign carry_no  = ~(wrap & up_i);
  assign borrow_no = ~(wrap & ~up_i);
endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             en_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             term;

  cnt_step #(.WIDTH(WIDTH)) u_step (
    .cur_i  (cnt_q),
    .up_i   (up_i),
    .nxt_o  (cnt_nxt),
    .term_o (term)
  );

  cnt_flags u_flags (
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .en_i      (en_i),
    .up_i      (up_i),
    .term_i    (term),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );

  // Priority: clear, then load, then count.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (en_i)   cnt_q <= cnt_nxt;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bidir_preset_counter_chk.sv
module bidir_preset_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic             en_i,
  input logic             up_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_no,
  input logic             borrow_no
);
  localparam logic [WIDTH-1:0] MAX_V = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE_V = WIDTH'(1);

  // R1
  clear_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && carry_no && borrow_no));

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && up_i) |=> count_o == WIDTH'($past(count_o) + ONE_V));

  // R3
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !up_i) |=> count_o == WIDTH'($past(count_o) - ONE_V));

  // R4
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |=> count_o == '0);

  // R6
  carry_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (count_o == MAX_V && up_i && en_i && !load_i));

  // R5
  borrow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |=> count_o == MAX_V);

  // R7
  borrow_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (count_o == '0 && !up_i && en_i && !load_i));

  // R6 R7
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_no || borrow_no);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o));

  // R9
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));
endmodule

bind bidir_preset_counter bidir_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .en_i       (en_i),
  .up_i       (up_i),
  .count_o    (count_o),
  .carry_no   (carry_no),
  .borrow_no  (borrow_no)
);

// File: tb/sim_bidir_preset_counter.sv
module sim_bidir_preset_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic         en_i = 1'b0;
  logic         up_i = 1'b0;
  logic [W-1:0] count_o;
  logic         carry_no;
  logic         borrow_no;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_cnt = '0;

  bidir_preset_counter #(.WIDTH(W)) u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .en_i       (en_i),
    .up_i       (up_i),
    .count_o    (count_o),
    .carry_no   (carry_no),
    .borrow_no  (borrow_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp_v, $time);
    end
  endtask

  // Drive at the falling edge, check the flags, clock once, check the count.
  task automatic cyc(input logic ld, input logic [W-1:0] v, input logic en,
                     input logic up, input string req);
    logic exp_c, exp_b;
    @(negedge clk_i);
    load_i = ld; load_val_i = v; en_i = en; up_i = up;
    #1;
    exp_c = !(exp_cnt == 4'hF && up && en && !ld);
    exp_b = !(exp_cnt == 4'h0 && !up && en && !ld);
    chk({req, " carry_no"}, int'(carry_no), int'(exp_c));
    chk({req, " borrow_no"}, int'(borrow_no), int'(exp_b));
    if (ld)      exp_cnt = v;
    else if (en) exp_cnt = up ? exp_cnt + 4'd1 : exp_cnt - 4'd1;
    @(posedge clk_i);
    #1;
    chk({req, " count"}, int'(count_o), int'(exp_cnt));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 count in clear", int'(count_o), 0);
    chk("R1 carry_no in clear", int'(carry_no), 1);
    chk("R1 borrow_no in clear", int'(borrow_no), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_cnt = '0;
  endtask

  task automatic t_up_all();
    for (int s = 0; s < 16; s++) begin
      cyc(1'b1, W'(s), 1'b0, 1'b1, "R9 preset");
      cyc(1'b0, '0, 1'b1, 1'b1, (s == 15) ? "R4 R6 up wrap" : "R2 R6 up");
    end
  endtask

  task automatic t_down_all();
    for (int s = 0; s < 16; s++) begin
      cyc(1'b1, W'(s), 1'b0, 1'b0, "R9 preset");
      cyc(1'b0, '0, 1'b1, 1'b0, (s == 0) ? "R5 R7 down wrap" : "R3 R7 down");
    end
  endtask

  task automatic t_run();
    cyc(1'b1, 4'hD, 1'b0, 1'b1, "R9 preset");
    for (int k = 0; k < 20; k++) cyc(1'b0, '0, 1'b1, 1'b1, "R2 R4 R6 run up");
    for (int k = 0; k < 20; k++) cyc(1'b0, '0, 1'b1, 1'b0, "R3 R5 R7 run down");
  endtask

  task automatic t_hold();
    cyc(1'b1, 4'hF, 1'b0, 1'b1, "R9 preset");
    cyc(1'b0, '0, 1'b0, 1'b1, "R8 hold at max up");
    cyc(1'b1, 4'h0, 1'b0, 1'b0, "R9 preset");
    cyc(1'b0, '0, 1'b0, 1'b0, "R8 hold at zero down");
    cyc(1'b0, '0, 1'b0, 1'b1, "R8 hold at zero up");
  endtask

  task automatic t_load_prio();
    cyc(1'b1, 4'hF, 1'b0, 1'b1, "R9 preset");
    cyc(1'b1, 4'h6, 1'b1, 1'b1, "R9 R6 load over up at max");
    cyc(1'b1, 4'h0, 1'b1, 1'b0, "R9 load with down");
    cyc(1'b1, 4'hA, 1'b1, 1'b0, "R9 R7 load over down at zero");
  endtask

  task automatic t_clear_prio();
    cyc(1'b1, 4'h7, 1'b0, 1'b1, "R9 preset");
    @(negedge clk_i);
    load_i = 1'b1; load_val_i = 4'h9; en_i = 1'b1; up_i = 1'b1;
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", int'(count_o), 0);
    @(posedge clk_i);
    #1;
    chk("R10 clear over load", int'(count_o), 0);
    chk("R1 carry_no in clear", int'(carry_no), 1);
    chk("R1 borrow_no in clear", int'(borrow_no), 1);
    @(negedge clk_i);
    load_i = 1'b0; en_i = 1'b0;
    rst_ni = 1'b1;
    exp_cnt = '0;
    cyc(1'b0, '0, 1'b1, 1'b1, "R2 after clear");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_up_all();
    t_down_all();
    t_run();
    t_hold();
    t_load_prio();
    t_clear_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule